// File: doc/BRIEF.md
# Instruction Prefix State Tracker

This block keeps track of the prefix bytes that come in front of an instruction in a 16-bit x86-style core. The decoder presents every opcode byte with a strobe. When the byte is a segment-override, lock or repeat prefix, the tracker records it. The recorded state stays in effect until the next real instruction has completed. The address generator reads a one-hot override vector. The string unit reads the two repeat flags.

The tracker also resolves the segment for a memory operand. The address generator gives the default segment that its addressing mode would pick and raises a request. One cycle later the tracker returns the chosen segment index and that segment's current value. An active override replaces the default.

Persistence rests on a single hold bit. A prefix byte sets it, and so does a re-arm request from the string unit while a repeated string instruction is still iterating. At each end-of-instruction strobe, a set hold bit is spent and the prefix flags survive. A clear hold bit means all prefix flags are dropped. Every output is registered, so results appear on the cycle after the clock edge that samples their inputs.

Top module: `pfx_tracker`

## Requirements
- R1: A synchronous active-high reset clears the override vector, both repeat flags, the hold bit, the segment-valid output, the segment index and the segment value to zero.
- R2: A strobed byte matching 001xx110 (0x26, 0x2E, 0x36, 0x3E) selects override index xx = bits [4:3] (0 = ES, 1 = CS, 2 = SS, 3 = DS). On the next cycle `ovr_oh` has only bit xx set, and the hold bit is set.
- R3: Prefixes that arrive back to back accumulate. A later segment prefix replaces an earlier one. Repeat and override flags coexist.
- R4: Byte 0xF0 sets the hold bit only. The override vector and the repeat flags keep their values.
- R5: Byte 0xF2 sets `rep_ne` and clears `rep_eq`. Byte 0xF3 sets `rep_eq` and clears `rep_ne`. Both set the hold bit. The two flags are never set together.
- R6: At an end-of-instruction strobe, if hold is set (including when a prefix or re-arm in the same cycle sets it), only hold is cleared. Otherwise the override vector and both repeat flags are cleared.
- R7: `rearm_req` sets hold in the same cycle as `insn_done` and takes priority over the clear, so the prefixes persist across repeated iterations.
- R8: When `agen_req` is high, on the next cycle `agen_vld` is 1, `agen_sel` is the active override index (or `agen_dflt` when no override is active), and `agen_base` is field `agen_sel` of `seg_bus` (field i = bits [16i+15:16i]). With no request, `agen_vld` is 0 and the index and value are held.
- R9: A strobed byte that is not one of the six prefix codes changes no prefix flag and does not change hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_stb | input | 1 | Opcode byte valid strobe |
| op_code | input | 8 | Opcode byte |
| insn_done | input | 1 | End-of-instruction strobe |
| rearm_req | input | 1 | Re-arm request from the string unit |
| agen_req | input | 1 | Segment resolve request |
| agen_dflt | input | 2 | Default segment index from the addressing mode |
| seg_bus | input | 64 | Four segment register values, index i at bits [16i+15:16i] |
| ovr_oh | output | 4 | One-hot active segment override |
| rep_ne | output | 1 | Repeat-while-not-equal flag |
| rep_eq | output | 1 | Repeat-while-equal flag |
| pfx_hold | output | 1 | Hold bit |
| agen_sel | output | 2 | Resolved segment index |
| agen_vld | output | 1 | Resolved segment valid |
| agen_base | output | 16 | Resolved segment value |

## Verification
Every result is due exactly one cycle after the edge that samples its stimulus. This covers the prefix flags and hold after a strobe, the clearing after `insn_done`, and the resolved segment after `agen_req`. The resolve path uses the override state as it stood before that same edge. The bench drives inputs just after a rising edge. It advances a behavioural model at the next rising edge, and it compares every output 1 ns later, on every clock, so each comparison falls in the cycle the result is due.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  localparam int SEG_IDX_W = 2;
  localparam int NUM_SEG   = 1 << SEG_IDX_W;

  localparam logic [7:0] OP_LOCK  = 8'hF0;
  localparam logic [7:0] OP_REPNE = 8'hF2;
  localparam logic [7:0] OP_REPE  = 8'hF3;
  // segment prefixes share the pattern 001xx110, xx = override index
  localparam logic [7:0] SEG_MASK = 8'b1110_0111;
  localparam logic [7:0] SEG_PAT  = 8'b0010_0110;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_SEG,
    PK_LOCK,
    PK_REPNE,
    PK_REPE
  } pfx_kind_e;

  typedef struct packed {
    pfx_kind_e             kind;
    logic [SEG_IDX_W-1:0]  seg_idx;
  } pfx_dec_t;

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
(
  input  logic       op_stb,
  input  logic [7:0] op_code,
  output pfx_dec_t   dec
);

  always_comb begin
    dec.kind    = PK_NONE;
    dec.seg_idx = op_code[4:3];
    if (op_stb) begin
      if ((op_code & SEG_MASK) == SEG_PAT) dec.kind = PK_SEG;
      else if (op_code == OP_LOCK)         dec.kind = PK_LOCK;
      else if (op_code == OP_REPNE)        dec.kind = PK_REPNE;
      else if (op_code == OP_REPE)         dec.kind = PK_REPE;
    end
  end

endmodule

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pfx_dec_t           dec,
  input  logic               insn_done,
  input  logic               rearm_req,
  output logic [NUM_SEG-1:0] ovr_q,
  output logic               rep_ne_q,
  output logic               rep_eq_q,
  output logic               hold_q
);

  logic [NUM_SEG-1:0] ovr_n;
  logic               ne_n, eq_n, hold_n;

  // ordered update: prefix capture, then re-arm, then end-of-instruction
  always_comb begin
    ovr_n  = ovr_q;
    ne_n   = rep_ne_q;
    eq_n   = rep_eq_q;
    hold_n = hold_q;
    unique case (dec.kind)
      PK_SEG: begin
        ovr_n              = '0;
        ovr_n[dec.seg_idx] = 1'b1;
        hold_n             = 1'b1;
      end
      PK_LOCK:  hold_n = 1'b1;
      PK_REPNE: begin ne_n = 1'b1; eq_n = 1'b0; hold_n = 1'b1; end
      PK_REPE:  begin eq_n = 1'b1; ne_n = 1'b0; hold_n = 1'b1; end
      default: ;
    endcase
    if (rearm_req) hold_n = 1'b1;
    if (insn_done) begin
      if (hold_n) begin
        hold_n = 1'b0;
      end else begin
        ovr_n = '0;
        ne_n  = 1'b0;
        eq_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q    <= '0;
      rep_ne_q <= 1'b0;
      rep_eq_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      ovr_q    <= ovr_n;
      rep_ne_q <= ne_n;
      rep_eq_q <= eq_n;
      hold_q   <= hold_n;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ovr_q == '0 && !rep_ne_q && !rep_eq_q && !hold_q));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ovr_q));

  assert_segpick_R2: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == PK_SEG && !insn_done) |=> (hold_q && ovr_q[$past(dec.seg_idx)]));

  assert_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == PK_LOCK && !insn_done) |=>
      (hold_q && $stable(ovr_q) && $stable(rep_ne_q) && $stable(rep_eq_q)));

  assert_rep_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rep_ne_q && rep_eq_q));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (insn_done && !hold_q && !rearm_req && dec.kind == PK_NONE) |=>
      (ovr_q == '0 && !rep_ne_q && !rep_eq_q));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    (insn_done && rearm_req && dec.kind == PK_NONE) |=>
      ($stable(ovr_q) && $stable(rep_ne_q) && $stable(rep_eq_q) && !hold_q));

  assert_other_R9: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == PK_NONE && !insn_done && !rearm_req) |=>
      ($stable(ovr_q) && $stable(rep_ne_q) && $stable(rep_eq_q) && $stable(hold_q)));

endmodule

// File: rtl/pfx_segsel.sv
module pfx_segsel
  import pfx_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [SEG_IDX_W-1:0]     dflt,
  input  logic [NUM_SEG-1:0]       ovr,
  input  logic [NUM_SEG*SEG_W-1:0] seg_bus,
  output logic [SEG_IDX_W-1:0]     sel_q,
  output logic                     vld_q,
  output logic [SEG_W-1:0]         base_q
);

  logic [SEG_W-1:0]     seg_arr [NUM_SEG];
  logic [SEG_IDX_W-1:0] ovr_idx;
  logic [SEG_IDX_W-1:0] pick;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
    assign seg_arr[g] = seg_bus[g*SEG_W +: SEG_W];
  end

  always_comb begin
    ovr_idx = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (ovr[i]) ovr_idx = SEG_IDX_W'(i);
    end
    pick = (|ovr) ? ovr_idx : dflt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      vld_q  <= 1'b0;
      base_q <= '0;
    end else begin
      vld_q <= req;
      if (req) begin
        sel_q  <= pick;
        base_q <= seg_arr[pick];
      end
    end
  end

  assert_dflt_R8: assert property (@(posedge clk) disable iff (rst)
    (req && ovr == '0) |=> (vld_q && sel_q == $past(dflt)));

  assert_ovr_R8: assert property (@(posedge clk) disable iff (rst)
    (req && ovr != '0) |=> (vld_q && ((($past(ovr) >> sel_q) & NUM_SEG'(1)) != '0)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!vld_q && $stable(sel_q) && $stable(base_q)));

endmodule

// File: rtl/pfx_tracker.sv
module pfx_tracker
  import pfx_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_stb,
  input  logic [7:0]               op_code,
  input  logic                     insn_done,
  input  logic                     rearm_req,
  input  logic                     agen_req,
  input  logic [SEG_IDX_W-1:0]     agen_dflt,
  input  logic [NUM_SEG*SEG_W-1:0] seg_bus,
  output logic [NUM_SEG-1:0]       ovr_oh,
  output logic                     rep_ne,
  output logic                     rep_eq,
  output logic                     pfx_hold,
  output logic [SEG_IDX_W-1:0]     agen_sel,
  output logic                     agen_vld,
  output logic [SEG_W-1:0]         agen_base
);

  pfx_dec_t dec;

  pfx_decode u_decode (
    .op_stb  (op_stb),
    .op_code (op_code),
    .dec     (dec)
  );

  pfx_state u_state (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .insn_done (insn_done),
    .rearm_req (rearm_req),
    .ovr_q     (ovr_oh),
    .rep_ne_q  (rep_ne),
    .rep_eq_q  (rep_eq),
    .hold_q    (pfx_hold)
  );

  pfx_segsel #(.SEG_W(SEG_W)) u_segsel (
    .clk     (clk),
    .rst     (rst),
    .req     (agen_req),
    .dflt    (agen_dflt),
    .ovr     (ovr_oh),
    .seg_bus (seg_bus),
    .sel_q   (agen_sel),
    .vld_q   (agen_vld),
    .base_q  (agen_base)
  );

endmodule

// File: tb/pfx_tracker_tb.sv
`timescale 1ns/1ps
module pfx_tracker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_stb = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic        insn_done = 1'b0;
  logic        rearm_req = 1'b0;
  logic        agen_req = 1'b0;
  logic [1:0]  agen_dflt = 2'd0;
  logic [63:0] seg_bus = 64'h0;
  logic [3:0]  ovr_oh;
  logic        rep_ne, rep_eq, pfx_hold, agen_vld;
  logic [1:0]  agen_sel;
  logic [15:0] agen_base;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_ovr = -1;
  bit m_ne = 0, m_eq = 0, m_hold = 0, m_vld = 0;
  int m_sel = 0;
  int m_base = 0;

  always #2.5 clk = ~clk;

  pfx_tracker u_dut (
    .clk(clk), .rst(rst), .op_stb(op_stb), .op_code(op_code),
    .insn_done(insn_done), .rearm_req(rearm_req), .agen_req(agen_req),
    .agen_dflt(agen_dflt), .seg_bus(seg_bus), .ovr_oh(ovr_oh),
    .rep_ne(rep_ne), .rep_eq(rep_eq), .pfx_hold(pfx_hold),
    .agen_sel(agen_sel), .agen_vld(agen_vld), .agen_base(agen_base)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // advance the model with the inputs sampled at this edge
  task automatic model_edge();
    bit h;
    int pre_ovr;
    pre_ovr = m_ovr;
    if (rst) begin
      m_ovr = -1; m_ne = 0; m_eq = 0; m_hold = 0;
      m_vld = 0; m_sel = 0; m_base = 0;
      return;
    end
    h = m_hold;
    if (op_stb) begin
      case (op_code)
        8'h26: begin m_ovr = 0; h = 1; end
        8'h2E: begin m_ovr = 1; h = 1; end
        8'h36: begin m_ovr = 2; h = 1; end
        8'h3E: begin m_ovr = 3; h = 1; end
        8'hF0: h = 1;
        8'hF2: begin m_ne = 1; m_eq = 0; h = 1; end
        8'hF3: begin m_eq = 1; m_ne = 0; h = 1; end
        default: ;
      endcase
    end
    if (rearm_req) h = 1;
    if (insn_done) begin
      if (h) h = 0;
      else begin m_ovr = -1; m_ne = 0; m_eq = 0; end
    end
    m_hold = h;
    m_vld = agen_req;
    if (agen_req) begin
      m_sel  = (pre_ovr >= 0) ? pre_ovr : int'(agen_dflt);
      m_base = int'((seg_bus >> (16 * m_sel)) & 64'hFFFF);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ovr_oh", int'(ovr_oh), (m_ovr < 0) ? 0 : (1 << m_ovr));
    chk(tag, "rep_ne", int'(rep_ne), int'(m_ne));
    chk(tag, "rep_eq", int'(rep_eq), int'(m_eq));
    chk(tag, "pfx_hold", int'(pfx_hold), int'(m_hold));
    chk(tag, "agen_vld", int'(agen_vld), int'(m_vld));
    chk(tag, "agen_sel", int'(agen_sel), m_sel);
    chk(tag, "agen_base", int'(agen_base), m_base);
  endtask

  task automatic step(string tag, bit stb, logic [7:0] op, bit dn, bit rr,
                      bit rq, logic [1:0] df);
    op_stb = stb; op_code = op; insn_done = dn; rearm_req = rr;
    agen_req = rq; agen_dflt = df;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  initial begin
    seg_bus = {16'h4D4D, 16'h3C3C, 16'h2B2B, 16'h1A1A};
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step("R1", 0, 8'h00, 0, 0, 0, 2'd0);
    // R1: state after reset
    chk("R1", "ovr_oh after reset", int'(ovr_oh), 0);
    chk("R1", "pfx_hold after reset", int'(pfx_hold), 0);
    rst = 1'b0;

    // R2: each segment prefix, consumed by a following instruction
    for (int s = 0; s < 4; s++) begin
      step("R2", 1, 8'h26 | (8'(s) << 3), 0, 0, 0, 2'd0);
      chk("R2", "onehot index", int'(ovr_oh), 1 << s);
      step("R2", 0, 8'h00, 1, 0, 0, 2'd0);
      step("R6", 0, 8'h00, 1, 0, 0, 2'd0);
      chk("R6", "cleared after real insn", int'(ovr_oh), 0);
    end

    // R3: back-to-back prefixes accumulate, later segment wins
    step("R3", 1, 8'h26, 1, 0, 0, 2'd0);
    step("R3", 1, 8'h3E, 1, 0, 0, 2'd0);
    step("R3", 1, 8'hF3, 1, 0, 0, 2'd0);
    chk("R3", "latest override", int'(ovr_oh), 4'b1000);
    chk("R3", "repeat kept", int'(rep_eq), 1);
    step("R8", 0, 8'h00, 0, 0, 1, 2'd2);
    chk("R8", "override replaces default", int'(agen_base), 16'h4D4D);
    step("R6", 0, 8'h00, 1, 0, 0, 2'd0);
    chk("R6", "all cleared", int'({ovr_oh, rep_ne, rep_eq}), 0);

    // R4: lock alone only sets hold
    step("R4", 1, 8'h36, 1, 0, 0, 2'd0);
    step("R4", 1, 8'hF0, 0, 0, 0, 2'd0);
    chk("R4", "hold set by lock", int'(pfx_hold), 1);
    chk("R4", "override untouched", int'(ovr_oh), 4'b0100);
    step("R4", 0, 8'h00, 1, 0, 0, 2'd0);
    step("R4", 0, 8'h00, 1, 0, 0, 2'd0);

    // R5: repeat flags exclusive
    step("R5", 1, 8'hF2, 1, 0, 0, 2'd0);
    chk("R5", "rep_ne", int'({rep_ne, rep_eq}), 2'b10);
    step("R5", 1, 8'hF3, 0, 0, 0, 2'd0);
    chk("R5", "rep_eq", int'({rep_ne, rep_eq}), 2'b01);
    step("R5", 0, 8'h00, 1, 0, 0, 2'd0);

    // R7: string iterations re-arm hold
    step("R7", 1, 8'h2E, 1, 0, 0, 2'd0);
    step("R7", 1, 8'hF3, 1, 0, 0, 2'd0);
    for (int k = 0; k < 4; k++) begin
      step("R7", 1, 8'hA4, 1, 1, 1, 2'd3);
      chk("R7", "kept across iteration", int'({ovr_oh, rep_eq}), 5'b00101);
    end
    step("R7", 1, 8'hA4, 1, 0, 0, 2'd0);
    chk("R7", "dropped at last iteration", int'({ovr_oh, rep_eq}), 0);

    // R9: other bytes change nothing
    step("R9", 1, 8'h36, 0, 0, 0, 2'd0);
    step("R9", 1, 8'h27, 0, 0, 0, 2'd0);
    step("R9", 1, 8'h0F, 0, 0, 0, 2'd0);
    step("R9", 1, 8'hF1, 0, 0, 0, 2'd0);
    chk("R9", "override after non-prefix", int'(ovr_oh), 4'b0100);
    step("R9", 0, 8'h00, 1, 0, 0, 2'd0);
    step("R9", 0, 8'h00, 1, 0, 0, 2'd0);

    // R8: default path and idle hold
    seg_bus = {16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD};
    step("R8", 0, 8'h00, 0, 0, 1, 2'd1);
    chk("R8", "default segment value", int'(agen_base), 16'hCCCC);
    step("R8", 0, 8'h00, 0, 0, 0, 2'd3);
    chk("R8", "idle valid low", int'(agen_vld), 0);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] pick [10];
      pick = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'hF0, 8'hF2, 8'hF3, 8'hA4, 8'h90, 8'hAE};
      if (n % 97 == 0) seg_bus = {$urandom, $urandom};
      step("R3", $urandom_range(0, 1) == 1, pick[$urandom_range(0, 9)],
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule